// File: doc/BRIEF.md
# Fiber Drift Phase Compensation Controller

This block closes a digital phase loop that keeps the recovered clock at a remote node steady while the optical fiber between the two nodes changes length with temperature. A phase detector compares the clock that comes back over the fiber with the local sampling clock, and an on-chip ADC turns that comparison into signed samples. The block takes those samples and works from the change since a reference moment, not from the absolute value. The fiber's forward and return paths are assumed to drift by equal amounts, so half of the round-trip change is taken as the one-way drift. The block then produces a phase-offset word for a DDS. The DDS pre-shifts the local fiber transmit clock so that the remote end sees no drift.

The loop includes the DDS offset, so every new measurement already carries the correction applied so far. The controller removes its own current offset from the measurement before it halves it. It then moves the offset toward the new target through a first-order integrator whose gain is a programmable right shift. A lock flag reports when the remaining error has stayed small for a run of samples. The logic runs in the fiber transmission clock domain.

Top module: `fiber_drift_comp`

## Requirements
- R1: While reset is asserted, and after it is released, `phase_word` is 0 and `locked` is 0.
- R2: Each 12-bit `sample` is taken as two's complement, sign-extended to 16 bits and shifted left by 4 (for example, 12'hFFF becomes 16'hFFF0) before any arithmetic.
- R3: The first sample with `sample_valid` high while `enable` is high, after reset or after `enable` was low, is stored as the baseline. That sample sets `phase_word` to 0 and clears the lock run. The result is visible the cycle after the sample.
- R4: Each later valid sample, scaled to m, updates the offset o (= `phase_word`). The error is e = m − baseline − o, taken as a signed 16-bit value. The target is t = −(e >>> 1), and the difference is d = t − o. The new offset is o + (d >>> k). All results are 16-bit and appear on `phase_word` the cycle after the sample.
- R5: The integrator shift k equals `gain_sel` + 1, so values 0 to 7 give shifts 1 to 8. The shifts are arithmetic, so they round toward minus infinity.
- R6: Every sum and difference wraps modulo 2^16.
- R7: `locked` rises the cycle after the 16th consecutive tracking sample whose |d| (signed 16-bit d, taken before the update) is strictly less than `lock_thresh`.
- R8: A tracking sample with |d| ≥ `lock_thresh` drops `locked` and restarts the run, effective the next cycle.
- R9: While `enable` is low, samples are ignored, `phase_word` holds its value and `locked` is 0. The first valid sample after re-enabling becomes a new baseline.
- R10: A cycle without `sample_valid` leaves `phase_word` and `locked` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fiber transmission domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the loop; low holds the output and re-arms baseline capture |
| gain_sel | input | 3 | Integrator shift minus one |
| lock_thresh | input | 16 | Unsigned bound on the error magnitude for lock |
| sample_valid | input | 1 | Qualifies `sample` |
| sample | input | 12 | Signed phase-detector sample from the ADC |
| phase_word | output | 16 | Registered DDS phase-offset word |
| locked | output | 1 | Lock status |

## Verification
Every result is due exactly one clock after the edge that takes the sample in: the baseline capture, the offset update and the lock change. One register stands between `sample` and both outputs. The bench drives each input on a falling edge and compares both outputs on the following falling edge, against a model that it advances at the moment it drives. The cycles with `sample_valid` low and the disabled cycles are compared on that same one-cycle grid, which shows that nothing moved.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
   typedef enum logic {
      LOOP_ARMING   = 1'b0,
      LOOP_TRACKING = 1'b1
   } loop_state_e;

   localparam int unsigned FDC_GAIN_SEL_W = 3;
endpackage

// File: rtl/fdc_sample_cond.sv
module fdc_sample_cond #(
   parameter int unsigned ADC_W    = 12,
   parameter int unsigned PH_W     = 16,
   parameter int unsigned PRESCALE = 4
) (
   input  logic [ADC_W-1:0] raw,
   output logic [PH_W-1:0]  scaled
);
   localparam int unsigned EXT_W = PH_W - ADC_W - PRESCALE;

   if (ADC_W + PRESCALE > PH_W) begin : g_bad_width
      $error("fdc_sample_cond: ADC_W + PRESCALE exceeds PH_W");
   end

   if (EXT_W == 0) begin : g_no_ext
      if (PRESCALE == 0) begin : g_plain
         assign scaled = raw;
      end else begin : g_shift
         assign scaled = {raw, {PRESCALE{1'b0}}};
      end
   end else begin : g_ext
      if (PRESCALE == 0) begin : g_plain
         assign scaled = {{EXT_W{raw[ADC_W-1]}}, raw};
      end else begin : g_shift
         assign scaled = {{EXT_W{raw[ADC_W-1]}}, raw, {PRESCALE{1'b0}}};
      end
   end
endmodule

// File: rtl/fdc_drift_est.sv
module fdc_drift_est #(
   parameter int unsigned PH_W = 16
) (
   input  logic [PH_W-1:0]        meas,
   input  logic [PH_W-1:0]        base,
   input  logic [PH_W-1:0]        offset,
   output logic signed [PH_W-1:0] diff
);
   logic signed [PH_W-1:0] round_trip;
   logic signed [PH_W-1:0] one_way;
   logic signed [PH_W-1:0] target;

   if (PH_W < 4) begin : g_bad_width
      $error("fdc_drift_est: PH_W too small");
   end

   always_comb begin
      round_trip = $signed(meas - base - offset);
      one_way    = round_trip >>> 1;
      target     = -one_way;
      diff       = target - $signed(offset);
   end
endmodule

// File: rtl/fdc_integrator.sv
module fdc_integrator #(
   parameter int unsigned PH_W   = 16,
   parameter int unsigned GSEL_W = 3,
   parameter bit          ROUND  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_zero,
   input  logic                   step_en,
   input  logic [GSEL_W-1:0]      gain_sel,
   input  logic signed [PH_W-1:0] diff,
   output logic [PH_W-1:0]        offset
);
   localparam int unsigned SH_W = GSEL_W + 1;

   logic [SH_W-1:0]        shamt;
   logic signed [PH_W-1:0] step;

   if ((1 << GSEL_W) > PH_W) begin : g_bad_gain
      $error("fdc_integrator: gain range exceeds word width");
   end

   assign shamt = {1'b0, gain_sel} + SH_W'(1);

   if (ROUND) begin : g_round
      logic signed [PH_W:0] wide;
      logic signed [PH_W:0] biased;
      logic signed [PH_W:0] shifted;
      always_comb begin
         wide    = {diff[PH_W-1], diff};
         biased  = wide + ((PH_W+1)'(1) << gain_sel);
         shifted = biased >>> shamt;
         step    = shifted[PH_W-1:0];
      end
   end else begin : g_floor
      assign step = diff >>> shamt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offset <= '0;
      end else if (load_zero) begin
         offset <= '0;
      end else if (step_en) begin
         offset <= offset + step;
      end
   end

   assert_zero_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_zero |=> offset == '0);
   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_zero || step_en) |=> $stable(offset));
endmodule

// File: rtl/fdc_lock_detect.sv
module fdc_lock_detect #(
   parameter int unsigned PH_W     = 16,
   parameter int unsigned LOCK_RUN = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   valid,
   input  logic signed [PH_W-1:0] diff,
   input  logic [PH_W-1:0]        thresh,
   output logic                   locked
);
   localparam int unsigned CNT_W = $clog2(LOCK_RUN + 1);

   logic [CNT_W-1:0]     run_cnt;
   logic signed [PH_W:0] dx;
   logic signed [PH_W:0] mag;
   logic                 below;

   if (LOCK_RUN < 2) begin : g_bad_run
      $error("fdc_lock_detect: LOCK_RUN must be at least 2");
   end

   always_comb begin
      dx    = {diff[PH_W-1], diff};
      mag   = dx[PH_W] ? -dx : dx;
      below = $unsigned(mag) < {1'b0, thresh};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         run_cnt <= '0;
         locked  <= 1'b0;
      end else if (valid) begin
         if (below) begin
            if (run_cnt != CNT_W'(LOCK_RUN)) begin
               run_cnt <= run_cnt + CNT_W'(1);
            end
            locked <= (run_cnt >= CNT_W'(LOCK_RUN - 1));
         end else begin
            run_cnt <= '0;
            locked  <= 1'b0;
         end
      end
   end

   assert_drop_on_excess_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr && !below) |=> !locked);
   assert_rise_needs_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(valid && below && !clr));
endmodule

// File: rtl/fiber_drift_comp.sv
module fiber_drift_comp #(
   parameter int unsigned ADC_W    = 12,
   parameter int unsigned PH_W     = 16,
   parameter int unsigned PRESCALE = 4,
   parameter int unsigned LOCK_RUN = 16,
   parameter bit          ROUND    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [2:0]       gain_sel,
   input  logic [PH_W-1:0]  lock_thresh,
   input  logic             sample_valid,
   input  logic [ADC_W-1:0] sample,
   output logic [PH_W-1:0]  phase_word,
   output logic             locked
);
   import fdc_pkg::*;

   loop_state_e            state;
   logic [PH_W-1:0]        meas;
   logic [PH_W-1:0]        base;
   logic signed [PH_W-1:0] diff;
   logic                   capture;
   logic                   track;

   assign capture = enable && sample_valid && (state == LOOP_ARMING);
   assign track   = enable && sample_valid && (state == LOOP_TRACKING);

   fdc_sample_cond #(
      .ADC_W(ADC_W), .PH_W(PH_W), .PRESCALE(PRESCALE)
   ) i_cond (
      .raw(sample), .scaled(meas)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LOOP_ARMING;
         base  <= '0;
      end else if (!enable) begin
         state <= LOOP_ARMING;
      end else if (capture) begin
         state <= LOOP_TRACKING;
         base  <= meas;
      end
   end

   fdc_drift_est #(.PH_W(PH_W)) i_est (
      .meas(meas), .base(base), .offset(phase_word), .diff(diff)
   );

   fdc_integrator #(
      .PH_W(PH_W), .GSEL_W(FDC_GAIN_SEL_W), .ROUND(ROUND)
   ) i_integ (
      .clk(clk), .rst_n(rst_n), .load_zero(capture), .step_en(track),
      .gain_sel(gain_sel), .diff(diff), .offset(phase_word)
   );

   fdc_lock_detect #(.PH_W(PH_W), .LOCK_RUN(LOCK_RUN)) i_lock (
      .clk(clk), .rst_n(rst_n), .clr(!enable || capture), .valid(track),
      .diff(diff), .thresh(lock_thresh), .locked(locked)
   );

   assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(phase_word));
   assert_unlocked_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !locked);
   assert_baseline_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (phase_word == '0) && !locked);
endmodule

// File: tb/test_fiber_drift_comp.sv
`timescale 1ns/1ps
module test_fiber_drift_comp;
   typedef struct packed {
      logic        en;
      logic        vld;
      logic [2:0]  g;
      logic [11:0] s;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b1, 3'd0, 12'h100},
      '{1'b1, 1'b1, 3'd0, 12'h120},
      '{1'b1, 1'b1, 3'd1, 12'h0F0},
      '{1'b1, 1'b0, 3'd1, 12'h7FF},
      '{1'b1, 1'b1, 3'd2, 12'h800},
      '{1'b1, 1'b1, 3'd3, 12'h7FF},
      '{1'b1, 1'b1, 3'd7, 12'h000},
      '{1'b1, 1'b1, 3'd4, 12'hF00},
      '{1'b0, 1'b1, 3'd4, 12'h300},
      '{1'b0, 1'b0, 3'd0, 12'h000},
      '{1'b1, 1'b1, 3'd2, 12'h050},
      '{1'b1, 1'b1, 3'd0, 12'h7FF},
      '{1'b1, 1'b1, 3'd0, 12'h800},
      '{1'b1, 1'b1, 3'd5, 12'h123},
      '{1'b1, 1'b1, 3'd6, 12'hABC},
      '{1'b1, 1'b1, 3'd0, 12'h001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [2:0]  gain_sel = '0;
   logic [15:0] lock_thresh = 16'h0040;
   logic        sample_valid = 1'b0;
   logic [11:0] sample = '0;
   logic [15:0] phase_word;
   logic        locked;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int  m_off = 0;
   int  m_base = 0;
   bit  m_arm = 1'b0;
   int  m_cnt = 0;
   bit  m_lk = 1'b0;

   always #2.5 clk = ~clk;

   fiber_drift_comp i_fiber_drift_comp (
      .clk(clk), .rst_n(rst_n), .enable(enable), .gain_sel(gain_sel),
      .lock_thresh(lock_thresh), .sample_valid(sample_valid), .sample(sample),
      .phase_word(phase_word), .locked(locked)
   );

   function automatic int sx16(int v);
      logic signed [15:0] t;
      t = v[15:0];
      return int'(t);
   endfunction

   task automatic check(string tag, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_off = 0; m_base = 0; m_arm = 1'b0; m_cnt = 0; m_lk = 1'b0;
   endtask

   // Drive at a falling edge, advance the model, compare at the next falling edge.
   task automatic step(bit en, bit vld, logic [2:0] g, logic [11:0] s, string tag);
      int m, e, est, tg, d, mag;
      enable = en; sample_valid = vld; gain_sel = g; sample = s;
      m = sx16(int'($signed(s)) * 16);
      if (!en) begin
         m_arm = 1'b0; m_cnt = 0; m_lk = 1'b0;
      end else if (vld) begin
         if (!m_arm) begin
            m_arm = 1'b1; m_base = m; m_off = 0; m_cnt = 0; m_lk = 1'b0;
         end else begin
            e   = sx16(m - m_base - m_off);
            est = e >>> 1;
            tg  = sx16(-est);
            d   = sx16(tg - m_off);
            mag = (d < 0) ? -d : d;
            if (mag < int'(lock_thresh)) begin
               if (m_cnt < 16) m_cnt++;
               m_lk = (m_cnt >= 16);
            end else begin
               m_cnt = 0; m_lk = 1'b0;
            end
            m_off = sx16(m_off + (d >>> (int'(g) + 1)));
         end
      end
      @(negedge clk);
      sample_valid = 1'b0;
      check({tag, " phase_word"}, int'(phase_word), m_off & 32'hFFFF);
      check({tag, " locked"}, int'(locked), int'(m_lk));
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset phase_word", int'(phase_word), 0);
      check("R1 reset locked", int'(locked), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release phase_word", int'(phase_word), 0);

      // Table walk: R4 tracking, R10 idle, R9 disabled, R3 re-baseline
      for (int i = 0; i < NVEC; i++) begin
         string tag;
         if (!VEC[i].en) tag = "R9";
         else if (!VEC[i].vld) tag = "R10";
         else tag = "R4";
         step(VEC[i].en, VEC[i].vld, VEC[i].g, VEC[i].s, tag);
      end

      // R2: sign extension and scaling; baseline 0, sample -1 -> +4 with shift 1
      step(1'b0, 1'b0, 3'd0, 12'h000, "R9");
      step(1'b1, 1'b1, 3'd0, 12'h000, "R3");
      check("R3 baseline zero", int'(phase_word), 0);
      step(1'b1, 1'b1, 3'd0, 12'hFFF, "R2");
      check("R2 scaled negative sample", int'(phase_word), 16'h0004);

      // R5 and R6: shift 8 on a difference of -2048 gives -8, which wraps to 16'hFFF8
      step(1'b0, 1'b0, 3'd0, 12'h000, "R9");
      step(1'b1, 1'b1, 3'd7, 12'h000, "R3");
      step(1'b1, 1'b1, 3'd7, 12'h100, "R5");
      check("R5 R6 max shift wrap", int'(phase_word), 16'hFFF8);

      // R10: idle cycles hold the word
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd0, 12'h555, "R10");
      check("R10 held", int'(phase_word), 16'hFFF8);

      // R7: a steady input converges and locks
      lock_thresh = 16'h0040;
      for (int i = 0; i < 48; i++) step(1'b1, 1'b1, 3'd0, 12'h040, "R7");
      check("R7 locked after run", int'(locked), 1);

      // R8: a large jump drops lock
      step(1'b1, 1'b1, 3'd0, 12'h740, "R8");
      check("R8 lock dropped", int'(locked), 0);

      // R9: disabling holds the word, and samples do not move it
      step(1'b0, 1'b1, 3'd3, 12'h321, "R9");
      step(1'b0, 1'b1, 3'd3, 12'h9AB, "R9");

      // R1: reset in mid-run
      rst_n = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      model_reset();
      check("R1 mid-run reset phase_word", int'(phase_word), 0);
      check("R1 mid-run reset locked", int'(locked), 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule